// File: doc/BRIEF.md
# Conversion Start and Host Bus Wait Gate

This block sits between an asynchronous, active-low conversion-start strobe and the host data bus of a sampling converter. It samples the strobe on the converter clock, drives an active-low busy flag while the strobe is low and for one clock after it returns high, and checks that the strobe was held low long enough. A long enough strobe produces a one-cycle conversion launch pulse at its rising edge. A strobe that is too short raises a one-cycle width error instead and launches nothing.

The same busy flag gates the host side. A control input picks one of two policies. With the control at 0, the output drivers stay off while busy is low, and every selected read or write raises a wait request so the host stalls until busy rises. With the control at 1, the bus behaves normally during busy and no wait is raised. The block also decodes reads to the FIFO data path or to the status path from one address bit. It forms the internal register write strobe from the low phase of the clock overlapping an active write.

Three states drive the start logic. ST_IDLE: busy is released. ST_LOW: the strobe is held low and a saturating counter measures its width. ST_REL: the strobe has just risen, busy is still low, and the launch pulse or the width error is presented. The transitions are:
- ST_IDLE to ST_LOW on a sampled low strobe.
- ST_LOW to itself while the strobe stays low.
- ST_LOW to ST_REL on a sampled high strobe.
- ST_REL to ST_IDLE unconditionally after one clock.

Top module: `cvs_conv_gate`

## Requirements
- R1: busy_n goes low at the first rising clock edge that samples start_n low, and not before.
- R2: busy_n returns high at the second rising clock edge that samples start_n high after a low period.
- R3: When start_n was sampled low on at least MIN_LOW edges (default 2), conv_go is high for exactly the one cycle after the first edge that samples start_n high again.
- R4: When start_n was sampled low on fewer than MIN_LOW edges, width_err is high for that same cycle and conv_go stays low; busy_n still follows R1 and R2.
- R5: With drv_en_busy = 0 and busy_n = 0, bus_oe is 0 whatever cs_n, rd_n and addr_hi are.
- R6: With drv_en_busy = 0 and busy_n = 0, wait_req is 1 whenever cs_n = 0 and either rd_n = 0 or wr_n = 0. Once busy_n rises, wait_req drops and a pending read drives bus_oe.
- R7: With drv_en_busy = 1, bus_oe equals (cs_n = 0 and rd_n = 0) regardless of busy_n, and wait_req is 0.
- R8: fifo_rd is bus_oe with addr_hi = 0. stat_rd is bus_oe with addr_hi = 1. They are never high together.
- R9: reg_wr_en is 1 only while clk is low, cs_n = 0, wr_n = 0 and addr_hi = 1, and the access is not blocked by R5 conditions. It is 0 throughout the clock-high phase.
- R10: During and right after reset, busy_n = 1 and conv_go = 0 and width_err = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_n | input | 1 | Asynchronous active-low conversion-start strobe |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr_hi | input | 1 | 0 selects FIFO data, 1 selects the status/control path |
| drv_en_busy | input | 1 | 1 allows bus drive during busy; 0 blocks it and stalls the host |
| busy_n | output | 1 | Active-low busy flag |
| bus_oe | output | 1 | Data bus output enable |
| wait_req | output | 1 | Host wait request (busy gated with chip select) |
| fifo_rd | output | 1 | Read strobe towards FIFO data |
| stat_rd | output | 1 | Read strobe towards status register |
| reg_wr_en | output | 1 | Internal register write enable (clock-low overlap) |
| conv_go | output | 1 | One-cycle conversion launch pulse |
| width_err | output | 1 | One-cycle flag for a too-short start strobe |

## Verification
A host access and a start strobe can land in the same cycle. The wait request must then appear at the same edge that pulls busy low. It must also release the pending read at the edge that lets busy rise. The bench holds chip select and read low across a whole start strobe and samples bus_oe, wait_req and fifo_rd after every edge. Those samples are compared with the busy timing that R1 and R2 predict. It also sweeps every combination of the five host inputs, with busy both held low and released. Every output is judged against arithmetic expectations, in both clock phases.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_REL  = 2'd2
    } cvs_state_e;

endpackage

// File: rtl/cvs_start_fsm.sv
module cvs_start_fsm
    import cvs_pkg::*;
#(
    parameter int MIN_LOW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_n,
    output logic busy_n,
    output logic conv_go,
    output logic width_err
);

    localparam int CNT_W = $clog2(MIN_LOW + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOW);

    cvs_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q,   cnt_d;
    logic             ok_q,    ok_d;

    // next-state and width counting
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ok_d    = ok_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!start_n) begin
                    state_d = ST_LOW;
                    cnt_d   = CNT_W'(1);
                end
            end
            ST_LOW: begin
                if (!start_n) begin
                    if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
                end else begin
                    state_d = ST_REL;
                    ok_d    = (cnt_q >= CNT_MAX);
                end
            end
            ST_REL: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ok_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ok_q    <= ok_d;
        end
    end

    // outputs decoded from the registered state
    always_comb begin
        busy_n    = (state_q == ST_IDLE);
        conv_go   = (state_q == ST_REL) &&  ok_q;
        width_err = (state_q == ST_REL) && !ok_q;
    end

endmodule

// File: rtl/cvs_bus_gate.sv
module cvs_bus_gate (
    input  logic clk,
    input  logic busy_n,
    input  logic drv_en_busy,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic addr_hi,
    output logic bus_oe,
    output logic wait_req,
    output logic fifo_rd,
    output logic stat_rd,
    output logic reg_wr_en
);

    logic rd_sel, wr_sel, blocked;

    always_comb begin
        rd_sel    = !cs_n && !rd_n;
        wr_sel    = !cs_n && !wr_n;
        blocked   = !drv_en_busy && !busy_n;
        bus_oe    = rd_sel && !blocked;
        wait_req  = (rd_sel || wr_sel) && blocked;
        fifo_rd   = bus_oe && !addr_hi;
        stat_rd   = bus_oe &&  addr_hi;
        reg_wr_en = wr_sel && addr_hi && !blocked && !clk;
    end

endmodule

// File: rtl/cvs_conv_gate.sv
module cvs_conv_gate #(
    parameter int MIN_LOW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic addr_hi,
    input  logic drv_en_busy,
    output logic busy_n,
    output logic bus_oe,
    output logic wait_req,
    output logic fifo_rd,
    output logic stat_rd,
    output logic reg_wr_en,
    output logic conv_go,
    output logic width_err
);

    cvs_start_fsm #(.MIN_LOW(MIN_LOW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_n   (start_n),
        .busy_n    (busy_n),
        .conv_go   (conv_go),
        .width_err (width_err)
    );

    cvs_bus_gate u_gate (
        .clk         (clk),
        .busy_n      (busy_n),
        .drv_en_busy (drv_en_busy),
        .cs_n        (cs_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .addr_hi     (addr_hi),
        .bus_oe      (bus_oe),
        .wait_req    (wait_req),
        .fifo_rd     (fifo_rd),
        .stat_rd     (stat_rd),
        .reg_wr_en   (reg_wr_en)
    );

endmodule

// File: rtl/cvs_conv_gate_chk.sv
module cvs_conv_gate_chk #(
    parameter int MIN_LOW = 2
) (
    input logic clk,
    input logic rst_n,
    input logic start_n,
    input logic cs_n,
    input logic rd_n,
    input logic wr_n,
    input logic drv_en_busy,
    input logic busy_n,
    input logic bus_oe,
    input logic wait_req,
    input logic fifo_rd,
    input logic stat_rd,
    input logic conv_go,
    input logic width_err
);

    localparam int CNT_W = $clog2(MIN_LOW + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOW);

    logic [CNT_W-1:0] low_run;

    always_ff @(posedge clk) begin
        if (!rst_n)                         low_run <= '0;
        else if (start_n)                   low_run <= '0;
        else if (low_run != CNT_MAX)        low_run <= low_run + 1'b1;
    end

    AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && !start_n) |=> !busy_n); // R1

    AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_go || width_err) |=> busy_n); // R2

    AST_GO_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        conv_go |-> ($past(low_run) >= CNT_MAX)); // R3

    AST_ERR_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        width_err |-> (($past(low_run) < CNT_MAX) && !conv_go)); // R4

    AST_OE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_en_busy && !busy_n) |-> !bus_oe); // R5

    AST_WAIT_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_en_busy && !busy_n && !cs_n && (!rd_n || !wr_n)) |-> wait_req); // R6

    AST_NO_WAIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en_busy |-> !wait_req); // R7

    AST_READ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({fifo_rd, stat_rd}) <= 1); // R8

    AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_go |=> !conv_go); // R3

endmodule

bind cvs_conv_gate cvs_conv_gate_chk #(.MIN_LOW(MIN_LOW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_n     (start_n),
    .cs_n        (cs_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .drv_en_busy (drv_en_busy),
    .busy_n      (busy_n),
    .bus_oe      (bus_oe),
    .wait_req    (wait_req),
    .fifo_rd     (fifo_rd),
    .stat_rd     (stat_rd),
    .conv_go     (conv_go),
    .width_err   (width_err)
);

// File: tb/test_cvs_conv_gate.sv
module test_cvs_conv_gate;

    localparam int MIN_LOW = 2;

    logic clk = 1'b0;
    logic rst_n, start_n, cs_n, rd_n, wr_n, addr_hi, drv_en_busy;
    logic busy_n, bus_oe, wait_req, fifo_rd, stat_rd, reg_wr_en, conv_go, width_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    cvs_conv_gate #(.MIN_LOW(MIN_LOW)) i_cvs_conv_gate (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .cs_n(cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .addr_hi(addr_hi), .drv_en_busy(drv_en_busy),
        .busy_n(busy_n), .bus_oe(bus_oe), .wait_req(wait_req), .fifo_rd(fifo_rd),
        .stat_rd(stat_rd), .reg_wr_en(reg_wr_en), .conv_go(conv_go), .width_err(width_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic after_pos();
        @(posedge clk); #1;
    endtask

    task automatic at_neg();
        @(negedge clk);
    endtask

    // one start strobe of w low edges; host idle
    task automatic strobe(input int w);
        bit good;
        good = (w >= MIN_LOW);
        at_neg();
        start_n = 1'b0;
        #1 chk("R1 busy before first edge", busy_n, 1);
        for (int k = 1; k <= w; k++) begin
            after_pos();
            chk("R1 busy low while strobe low", busy_n, 0);
            chk("R3 no go while low", conv_go, 0);
        end
        at_neg();
        start_n = 1'b1;
        after_pos();
        chk("R2 busy held one edge after rise", busy_n, 0);
        chk("R3 launch pulse", conv_go, int'(good));
        chk("R4 width error", width_err, int'(!good));
        after_pos();
        chk("R2 busy released", busy_n, 1);
        chk("R3 launch one cycle", conv_go, 0);
        chk("R4 error one cycle", width_err, 0);
        after_pos();
    endtask

    // sweep all host-side combinations against arithmetic expectations
    task automatic host_sweep(input bit busy_low);
        for (int v = 0; v < 32; v++) begin
            bit c, r, w, a, e, blk, rs, ws;
            at_neg();
            {c, r, w, a, e} = 5'(v);
            cs_n = c; rd_n = r; wr_n = w; addr_hi = a; drv_en_busy = e;
            #1;
            blk = !e && busy_low;
            rs  = !c && !r;
            ws  = !c && !w;
            chk("R10 busy level in sweep", busy_n, int'(!busy_low));
            chk(blk ? "R5 oe blocked" : "R7 oe normal", bus_oe, int'(rs && !blk));
            chk(e ? "R7 no wait" : "R6 wait request", wait_req, int'((rs || ws) && blk));
            chk("R8 fifo read", fifo_rd, int'(rs && !blk && !a));
            chk("R8 status read", stat_rd, int'(rs && !blk && a));
            chk("R9 write enable low phase", reg_wr_en, int'(ws && a && !blk));
            after_pos();
            chk("R9 write enable high phase", reg_wr_en, 0);
        end
        at_neg();
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr_hi = 1'b0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start_n = 1'b1; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        addr_hi = 1'b0; drv_en_busy = 1'b0;
        after_pos();
        after_pos();
        chk("R10 reset busy", busy_n, 1);
        chk("R10 reset go", conv_go, 0);
        chk("R10 reset error", width_err, 0);
        at_neg();
        rst_n = 1'b1;
        after_pos();
        chk("R10 busy after reset", busy_n, 1);

        // R1 R2 R3 R4: width sweep around the limit
        for (int w = 1; w <= 6; w++) strobe(w);

        // R5 R6 R7 R8 R9 with busy released
        host_sweep(1'b0);

        // hold the strobe low, then sweep with busy low
        at_neg();
        start_n = 1'b0;
        after_pos();
        after_pos();
        after_pos();
        host_sweep(1'b1);
        at_neg();
        start_n = 1'b1;
        after_pos();
        chk("R3 go after long hold", conv_go, 1);
        after_pos();
        after_pos();

        // R6: read pending across a strobe, stalled then released
        at_neg();
        drv_en_busy = 1'b0; cs_n = 1'b0; rd_n = 1'b0; addr_hi = 1'b0;
        #1;
        chk("R6 read proceeds while idle", bus_oe, 1);
        chk("R6 no wait while idle", wait_req, 0);
        start_n = 1'b0;
        after_pos();
        chk("R6 wait rises with busy", wait_req, 1);
        chk("R5 oe drops with busy", bus_oe, 0);
        after_pos();
        chk("R6 wait held", wait_req, 1);
        at_neg();
        start_n = 1'b1;
        after_pos();
        chk("R6 wait held after rise", wait_req, 1);
        chk("R8 fifo read stalled", fifo_rd, 0);
        after_pos();
        chk("R6 wait released", wait_req, 0);
        chk("R6 read completes", bus_oe, 1);
        chk("R8 fifo read completes", fifo_rd, 1);

        // R7: same collision with drive allowed during busy
        at_neg();
        drv_en_busy = 1'b1; addr_hi = 1'b1;
        start_n = 1'b0;
        after_pos();
        chk("R7 busy low", busy_n, 0);
        chk("R7 no wait", wait_req, 0);
        chk("R7 oe kept", bus_oe, 1);
        chk("R8 status read kept", stat_rd, 1);
        after_pos();
        at_neg();
        start_n = 1'b1; cs_n = 1'b1; rd_n = 1'b1;
        after_pos();
        after_pos();
        after_pos();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule